// File: doc/BRIEF.md
# Interrupt Router Indirect Register Window

This block is the host-facing register file of a 24-pin interrupt router. The host sees only two 32-bit locations. The first is an index register at offset 0x00. The second is a data window at offset 0x10, which reads or writes whichever internal register the index selects. Behind the window are:

- an identifier register;
- a version register, read-only;
- an arbitration register, which mirrors the identifier;
- one 64-bit routing entry per pin, reached as two 32-bit halves.

The block keeps the status bits of every routing entry out of the host's reach. A neighbouring delivery engine owns those bits and loads them through a status port. The block also emits two one-cycle requests. One tells the trigger-mode logic to recompute its tables. The other tells the delivery engine that a pin has become deliverable because of a table write.

Host reads return data one cycle after the access, flagged by a valid strobe. Message generation and the bus fabric sit outside the block.

Top module: `irq_route_regwin`

## Requirements
- R1: Only accesses with `acc_size` = 4 at offset 0x00 (index) or offset 0x10 (window) take effect. Any other read returns 0, and any other write changes no state.
- R2: The index register stores all 32 written bits and reads them back at offset 0x00. The window decodes only bits 7:0 of the index.
- R3: A window write at index 0 keeps only data bits 27:24 as the identifier. Reads at index 0 and index 2 both return the identifier in bits 27:24, with all other bits zero. Writes at index 2 are ignored.
- R4: Index 1 reads as ((pins−1) << 16) | 0x11, which is 0x00170011 for 24 pins. Writes to it are ignored.
- R5: Pin p's entry bits 31:0 sit at index 0x10+2p and bits 63:32 at index 0x10+2p+1. Indices 3 to 0x0F and indices from 0x10+2·pins upward read as 0.
- R6: After reset the index register and the identifier are 0, and every entry is 0x0001000000010000. Bit 16 of an entry is the mask bit, so every pin starts masked.
- R7: Entry bit 12 (delivery status) and bit 14 (remote IRR) ignore host writes. When `stat_we[p]` is high they load `stat_dlvs[p]` and `stat_rirr[p]`, and reads show them.
- R8: `tmr_recalc` is high for exactly the one cycle after a window write to an entry, and only when that write changed an entry bit other than bit 16 (mask) or bit 13 (polarity).
- R9: In the cycle after a window write to pin p's entry, `dlv_req` pulses with `dlv_pin` = p if the resulting entry has bit 16 clear and bit 14 clear and `pin_active[p]` is high. Otherwise `dlv_req` stays low.
- R10: `acc_rvalid` is high exactly in the cycle after a read access, and `acc_rdata` holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset of the access |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read data strobe |
| pin_active | input | 24 | Per pin: assertion count is positive |
| stat_we | input | 24 | Per pin: load the status bits |
| stat_rirr | input | 24 | Remote IRR value to load |
| stat_dlvs | input | 24 | Delivery-status value to load |
| tmr_recalc | output | 1 | Trigger-mode recompute pulse |
| dlv_req | output | 1 | Delivery re-evaluation pulse |
| dlv_pin | output | 5 | Pin named by dlv_req |

## Verification
The hardest case to reach is the delivery request, because it needs three conditions at once:

- the host has unmasked the entry;
- the engine has left remote IRR clear through the status port;
- the pin's activity input is high.

The bench builds this up in steps on a single pin. First it writes entries that differ only in the mask bit or the polarity bit, and expects neither pulse. It then changes the vector with the pin inactive, and later rewrites the same entry with the pin active. Finally it sets remote IRR through the status port and repeats the write, confirming that the request is suppressed and that the host write left the protected bit intact.

// File: rtl/irw_pkg.sv
package irw_pkg;
    localparam int ENTRY_W   = 64;
    localparam int WORD_W    = 32;
    // entry field positions decoded by the delivery and trigger-mode logic
    localparam int BIT_DLVS  = 12;
    localparam int BIT_POL   = 13;
    localparam int BIT_RIRR  = 14;
    localparam int BIT_MASK  = 16;
    localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h0001_0000_0001_0000;
    localparam logic [ENTRY_W-1:0] RO_BITS     = (64'd1 << BIT_RIRR) | (64'd1 << BIT_DLVS);
    localparam logic [ENTRY_W-1:0] NOCFG_BITS  = (64'd1 << BIT_MASK) | (64'd1 << BIT_POL);
endpackage

// File: rtl/irw_decode.sv
module irw_decode #(
    parameter int NPINS = 24,
    parameter int PIN_W = 5
) (
    input  logic [7:0]       idx,
    output logic             is_id,
    output logic             is_ver,
    output logic             is_arb,
    output logic             is_tbl,
    output logic [PIN_W-1:0] tbl_pin,
    output logic             tbl_hi
);
    localparam int TBL_BASE = 16;
    localparam int TBL_END  = TBL_BASE + 2 * NPINS;

    logic [8:0] rel;

    always_comb begin
        is_id   = (idx == 8'd0);
        is_ver  = (idx == 8'd1);
        is_arb  = (idx == 8'd2);
        is_tbl  = (32'(idx) >= TBL_BASE) && (32'(idx) < TBL_END);
        rel     = {1'b0, idx} - 9'(TBL_BASE);
        tbl_hi  = rel[0];
        tbl_pin = is_tbl ? PIN_W'(rel[8:1]) : '0;
    end
endmodule

// File: rtl/irw_entry_merge.sv
module irw_entry_merge
    import irw_pkg::*;
(
    input  logic [ENTRY_W-1:0] old_entry,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               hi_half,
    output logic [ENTRY_W-1:0] new_entry,
    output logic               cfg_changed
);
    logic [ENTRY_W-1:0] wr_bits;
    logic [ENTRY_W-1:0] wr_data;
    logic [ENTRY_W-1:0] keep;

    always_comb begin
        wr_bits     = hi_half ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
        wr_data     = hi_half ? {wdata, 32'h0} : {32'h0, wdata};
        keep        = ~wr_bits | RO_BITS;
        new_entry   = (old_entry & keep) | (wr_data & ~RO_BITS & wr_bits);
        cfg_changed = |((old_entry ^ new_entry) & ~NOCFG_BITS);
    end
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
    import irw_pkg::*;
#(
    parameter int NPINS   = 24,
    parameter int PIN_W   = $clog2(NPINS),
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_offset,
    input  logic [2:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    output logic              acc_rvalid,
    input  logic [NPINS-1:0]  pin_active,
    input  logic [NPINS-1:0]  stat_we,
    input  logic [NPINS-1:0]  stat_rirr,
    input  logic [NPINS-1:0]  stat_dlvs,
    output logic              tmr_recalc,
    output logic              dlv_req,
    output logic [PIN_W-1:0]  dlv_pin
);
    localparam logic [ADDR_W-1:0] OFF_SEL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_WIN = ADDR_W'(16);
    localparam logic [31:0] VERSION_VAL = 32'((NPINS - 1) << 16) | 32'h11;

    typedef struct packed {
        logic [31:0]                    sel;
        logic [3:0]                     id;
        logic [NPINS-1:0][ENTRY_W-1:0]  tbl;
        logic [31:0]                    rdata;
        logic                           rvalid;
        logic                           tmr;
        logic                           dlv;
        logic [PIN_W-1:0]               dlv_pin;
    } state_t;

    state_t st_q, st_d;

    logic             is_id, is_ver, is_arb, is_tbl, tbl_hi;
    logic [PIN_W-1:0] tbl_pin;
    logic [ENTRY_W-1:0] old_entry, merged;
    logic             cfg_changed;
    logic             size_ok, hit_sel, hit_win, tbl_wr;
    logic [31:0]      win_rd;

    irw_decode #(.NPINS(NPINS), .PIN_W(PIN_W)) u_decode (
        .idx     (st_q.sel[7:0]),
        .is_id   (is_id),
        .is_ver  (is_ver),
        .is_arb  (is_arb),
        .is_tbl  (is_tbl),
        .tbl_pin (tbl_pin),
        .tbl_hi  (tbl_hi)
    );

    assign old_entry = st_q.tbl[tbl_pin];

    irw_entry_merge u_merge (
        .old_entry   (old_entry),
        .wdata       (acc_wdata),
        .hi_half     (tbl_hi),
        .new_entry   (merged),
        .cfg_changed (cfg_changed)
    );

    always_comb begin
        size_ok = (acc_size == 3'd4);
        hit_sel = acc_valid && size_ok && (acc_offset == OFF_SEL);
        hit_win = acc_valid && size_ok && (acc_offset == OFF_WIN);
        tbl_wr  = hit_win && acc_write && is_tbl;

        if (is_id || is_arb)
            win_rd = {4'h0, st_q.id, 24'h0};
        else if (is_ver)
            win_rd = VERSION_VAL;
        else if (is_tbl)
            win_rd = tbl_hi ? old_entry[63:32] : old_entry[31:0];
        else
            win_rd = '0;

        st_d         = st_q;
        st_d.rvalid  = 1'b0;
        st_d.tmr     = 1'b0;
        st_d.dlv     = 1'b0;
        st_d.dlv_pin = '0;

        if (acc_valid && !acc_write) begin
            st_d.rvalid = 1'b1;
            if (hit_sel)
                st_d.rdata = st_q.sel;
            else if (hit_win)
                st_d.rdata = win_rd;
            else
                st_d.rdata = '0;
        end

        if (hit_sel && acc_write)
            st_d.sel = acc_wdata;
        if (hit_win && acc_write && is_id)
            st_d.id = acc_wdata[27:24];
        if (tbl_wr)
            st_d.tbl[tbl_pin] = merged;

        for (int p = 0; p < NPINS; p++) begin
            if (stat_we[p]) begin
                st_d.tbl[p][BIT_RIRR] = stat_rirr[p];
                st_d.tbl[p][BIT_DLVS] = stat_dlvs[p];
            end
        end

        if (tbl_wr) begin
            st_d.tmr = cfg_changed;
            if (!st_d.tbl[tbl_pin][BIT_MASK] && !st_d.tbl[tbl_pin][BIT_RIRR]
                && pin_active[tbl_pin]) begin
                st_d.dlv     = 1'b1;
                st_d.dlv_pin = tbl_pin;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel     <= '0;
            st_q.id      <= '0;
            st_q.tbl     <= {NPINS{ENTRY_RESET}};
            st_q.rdata   <= '0;
            st_q.rvalid  <= 1'b0;
            st_q.tmr     <= 1'b0;
            st_q.dlv     <= 1'b0;
            st_q.dlv_pin <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_rdata  = st_q.rdata;
    assign acc_rvalid = st_q.rvalid;
    assign tmr_recalc = st_q.tmr;
    assign dlv_req    = st_q.dlv;
    assign dlv_pin    = st_q.dlv_pin;
endmodule

// File: rtl/irw_checker.sv
module irw_checker #(
    parameter int NPINS  = 24,
    parameter int PIN_W  = 5,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_offset,
    input logic [2:0]        acc_size,
    input logic [31:0]       acc_rdata,
    input logic              acc_rvalid,
    input logic              tmr_recalc,
    input logic              dlv_req,
    input logic [PIN_W-1:0]  dlv_pin
);
    logic win_write, bad_read;
    assign win_write = acc_valid && acc_write && acc_size == 3'd4 && acc_offset == ADDR_W'(16);
    assign bad_read  = acc_valid && !acc_write &&
                       !(acc_size == 3'd4 && (acc_offset == ADDR_W'(0) || acc_offset == ADDR_W'(16)));

    assert_bad_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bad_read |=> (acc_rdata == 32'h0));

    assert_tmr_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_recalc |-> $past(win_write));

    assert_dlv_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_req |-> $past(win_write));

    assert_dlv_pin_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_req |-> (32'(dlv_pin) < NPINS));

    assert_rvalid_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> acc_rvalid);

    assert_no_rvalid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !acc_rvalid);
endmodule

bind irq_route_regwin irw_checker #(.NPINS(NPINS), .PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_irw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_offset (acc_offset),
    .acc_size   (acc_size),
    .acc_rdata  (acc_rdata),
    .acc_rvalid (acc_rvalid),
    .tmr_recalc (tmr_recalc),
    .dlv_req    (dlv_req),
    .dlv_pin    (dlv_pin)
);

// File: tb/test_irq_route_regwin.sv
module test_irq_route_regwin;
    localparam int NPINS = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_offset = '0;
    logic [2:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_rvalid;
    logic [NPINS-1:0] pin_active = '0;
    logic [NPINS-1:0] stat_we = '0;
    logic [NPINS-1:0] stat_rirr = '0;
    logic [NPINS-1:0] stat_dlvs = '0;
    logic        tmr_recalc;
    logic        dlv_req;
    logic [4:0]  dlv_pin;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_route_regwin i_irq_route_regwin (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .pin_active(pin_active),
        .stat_we(stat_we), .stat_rirr(stat_rirr), .stat_dlvs(stat_dlvs),
        .tmr_recalc(tmr_recalc), .dlv_req(dlv_req), .dlv_pin(dlv_pin)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  off;
        logic [2:0]  sz;
        logic [31:0] dat;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 3'd4, 32'h0000_0000},  // R6 index reset
        '{1'b0, 8'h00, 3'd4, 32'h0000_0001},
        '{1'b1, 8'h10, 3'd4, 32'h0017_0011},  // R4 version
        '{1'b0, 8'h10, 3'd4, 32'hFFFF_FFFF},
        '{1'b1, 8'h10, 3'd4, 32'h0017_0011},  // R4 write ignored
        '{1'b0, 8'h00, 3'd4, 32'h0000_0000},
        '{1'b1, 8'h10, 3'd4, 32'h0000_0000},  // R6 id reset
        '{1'b0, 8'h10, 3'd4, 32'hFFFF_FFFF},
        '{1'b1, 8'h10, 3'd4, 32'h0F00_0000},  // R3 id bits kept
        '{1'b0, 8'h00, 3'd4, 32'h0000_0002},
        '{1'b1, 8'h10, 3'd4, 32'h0F00_0000},  // R3 arb mirrors id
        '{1'b0, 8'h10, 3'd4, 32'h0000_0000},
        '{1'b1, 8'h10, 3'd4, 32'h0F00_0000},  // R3 arb write ignored
        '{1'b0, 8'h00, 3'd4, 32'hABCD_0010},
        '{1'b1, 8'h00, 3'd4, 32'hABCD_0010},  // R2 full index stored
        '{1'b1, 8'h10, 3'd4, 32'h0001_0000},  // R2 low byte decoded, R6
        '{1'b0, 8'h00, 3'd4, 32'h0000_0011},
        '{1'b1, 8'h10, 3'd4, 32'h0001_0000},  // R6 high half
        '{1'b0, 8'h00, 3'd4, 32'h0000_003F},
        '{1'b1, 8'h10, 3'd4, 32'h0001_0000},  // R5 last pin high half
        '{1'b0, 8'h00, 3'd4, 32'h0000_0040},
        '{1'b1, 8'h10, 3'd4, 32'h0000_0000},  // R5 past table
        '{1'b0, 8'h00, 3'd4, 32'h0000_0003},
        '{1'b1, 8'h10, 3'd4, 32'h0000_0000},  // R5 unused index
        '{1'b1, 8'h04, 3'd4, 32'h0000_0000},  // R1 bad offset
        '{1'b1, 8'h10, 3'd2, 32'h0000_0000},  // R1 bad size
        '{1'b0, 8'h00, 3'd2, 32'h0000_0012},
        '{1'b1, 8'h00, 3'd4, 32'h0000_0003},  // R1 narrow write ignored
        '{1'b0, 8'h00, 3'd4, 32'h0000_0012},
        '{1'b0, 8'h10, 3'd4, 32'hFFFF_FFFF},
        '{1'b1, 8'h10, 3'd4, 32'hFFFF_AFFF},  // R7 protected bits stay 0
        '{1'b0, 8'h00, 3'd4, 32'h0000_0013},
        '{1'b0, 8'h10, 3'd4, 32'h1234_5678},
        '{1'b1, 8'h10, 3'd4, 32'h1234_5678}   // R5 odd index = high half
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one access; returns with outputs of that access visible
    task automatic acc(input logic rd, input logic [7:0] off, input logic [2:0] sz,
                       input logic [31:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = !rd; acc_offset = off; acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic wr_pin2(input logic [31:0] wd, input logic exp_tmr, input logic exp_dlv,
                           input string req);
        acc(1'b0, 8'h10, 3'd4, wd);
        check({req, " tmr_recalc"}, 32'(tmr_recalc), 32'(exp_tmr));
        check({req, " dlv_req"}, 32'(dlv_req), 32'(exp_dlv));
        if (exp_dlv) check({req, " dlv_pin"}, 32'(dlv_pin), 32'd2);
    endtask

    task automatic load_stat2(input logic rirr, input logic dlvs);
        @(negedge clk);
        stat_we[2] = 1'b1; stat_rirr[2] = rirr; stat_dlvs[2] = dlvs;
        @(negedge clk);
        stat_we = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R6 tmr_recalc idle", 32'(tmr_recalc), 32'd0);
        check("R6 dlv_req idle", 32'(dlv_req), 32'd0);

        for (int i = 0; i < NV; i++) begin
            acc(VECS[i].rd, VECS[i].off, VECS[i].sz, VECS[i].dat);
            if (VECS[i].rd) begin
                check("R10 rvalid", 32'(acc_rvalid), 32'd1);
                check($sformatf("vector %0d R1-R7", i), acc_rdata, VECS[i].dat);
            end
        end
        @(negedge clk);
        check("R10 rvalid drops", 32'(acc_rvalid), 32'd0);

        // pin 2 low half: trigger-mode and delivery side effects
        acc(1'b0, 8'h00, 3'd4, 32'h0000_0014);
        wr_pin2(32'h0001_0000, 1'b0, 1'b0, "R8 no change");
        wr_pin2(32'h0001_2000, 1'b0, 1'b0, "R8 polarity only");
        wr_pin2(32'h0000_2000, 1'b0, 1'b0, "R8 mask only, R9 inactive");
        wr_pin2(32'h0000_0031, 1'b1, 1'b0, "R8 vector change");
        @(negedge clk);
        check("R8 pulse one cycle", 32'(tmr_recalc), 32'd0);
        pin_active[2] = 1'b1;
        wr_pin2(32'h0000_0031, 1'b0, 1'b1, "R9 deliverable");
        @(negedge clk);
        check("R9 pulse one cycle", 32'(dlv_req), 32'd0);
        load_stat2(1'b1, 1'b0);
        wr_pin2(32'h0000_0031, 1'b0, 1'b0, "R9 remote IRR blocks");
        acc(1'b1, 8'h10, 3'd4, 32'h0);
        check("R7 remote IRR kept over write", acc_rdata, 32'h0000_4031);
        load_stat2(1'b0, 1'b1);
        wr_pin2(32'h0001_0031, 1'b0, 1'b0, "R9 masked blocks");
        acc(1'b1, 8'h10, 3'd4, 32'h0);
        check("R7 delivery status visible", acc_rdata, 32'h0001_1031);

        // high half: destination change
        acc(1'b0, 8'h00, 3'd4, 32'h0000_0015);
        wr_pin2(32'hFF00_0000, 1'b1, 1'b0, "R8 destination change");

        // reset restores everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        acc(1'b1, 8'h00, 3'd4, 32'h0);
        check("R6 index after reset", acc_rdata, 32'h0);
        acc(1'b0, 8'h00, 3'd4, 32'h0000_0015);
        acc(1'b1, 8'h10, 3'd4, 32'h0);
        check("R6 entry after reset", acc_rdata, 32'h0001_0000);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule